// File: doc/BRIEF.md
# Three-Phase Gate Driver Fault Manager

This block sits between a motor-control PWM generator and the six gate drivers of a three-phase half bridge. While the bridge is healthy, each gate enable follows its PWM input through one register. An overcurrent or supply-undervoltage flag switches every gate enable off at once. The block then drives a pull-down onto the shared shutdown/fault line that the host and the block both watch. Switch-off does not wait for that line to fall, so the external RC network on the line has no effect on protection delay.

The pull-down is held for a minimum time set per fault kind. It stays on while the fault persists, and it lets go only after the line has sunk below its low unlatch level. The gates come back only when the line climbs above its high logic level again. The pull-down time plus the external RC therefore sets the restart time. The analog side is represented by input flags: the comparators, the two line thresholds and the supply monitor. All of these flags are resynchronised with two-flop stages. A cause register reports the most recent fault kind until restart.

Top module: `gd_fault_mgr`

## Requirements
- R1: An overcurrent flag that is high at one rising edge forces all six gate enables low by the second rising edge after it, whatever the line levels are.
- R2: A one-cycle overcurrent event, with the line-low flag already high, holds the pull-down on for exactly OC_MIN_CYC+1 consecutive cycles.
- R3: An overcurrent event lasting L cycles, with L greater than OC_MIN_CYC+1, holds the pull-down on for exactly L cycles.
- R4: An undervoltage event holds the pull-down on for UV_MIN_CYC+1 cycles if it is short. If it lasts L cycles, with L greater than UV_MIN_CYC+1, the pull-down stays on for L cycles.
- R5: The pull-down is not released while the synchronised line-low flag is low, even after every timer has run out. It releases within four cycles of that flag rising.
- R6: After a fault, the gates stay low until the pull-down is off and the line-high flag has been seen high. From then on they follow the PWM inputs again. A gate enable is never high while the pull-down is on.
- R7: With no fault present, a low line-high flag forces all gates low by the third edge. It does not turn on the pull-down or change the fault cause.
- R8: Overcurrent is detected and recorded while undervoltage is active. In that case the cause changes to overcurrent.
- R9: When overcurrent and undervoltage start together, each minimum timer runs on its own. The pull-down stays on until the longer of the two has run out.
- R10: fault_cause encodes 0 for none, 1 for overcurrent and 2 for undervoltage. It takes the newest fault, and overcurrent wins when both start in the same cycle. It returns to 0 at restart, and no gate enable is high while it is non-zero.
- R11: While reset is high, all gate enables are low, the pull-down is off and fault_cause is 0.
- R12: With no fault and the line-high flag high, gate_hi and gate_lo equal pwm_hi and pwm_lo, delayed by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | 3 | High-side PWM requests for phases U, V, W (bit 0 = U) |
| pwm_lo | input | 3 | Low-side PWM requests for phases U, V, W (bit 0 = U) |
| oc_flag | input | 1 | Overcurrent comparator output, asynchronous |
| uv_flag | input | 1 | Driver supply below its turn-on level, asynchronous |
| pin_high | input | 1 | Shutdown line above its high logic threshold |
| pin_low | input | 1 | Shutdown line below its low unlatch threshold |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| pd_en | output | 1 | Enable for the open-drain pull-down on the shutdown line |
| fault_cause | output | 2 | Most recent fault kind: 0 none, 1 overcurrent, 2 undervoltage |

## Verification
Two functions can fall in the same cycle: the overcurrent minimum timer and the undervoltage minimum timer. Both are started and may expire on the same clock. The bench raises both flags at the same edge. It then judges the pull-down length against the longer window and checks the cause against the overcurrent priority. It also nests a one-cycle overcurrent inside a long undervoltage event. There the pull-down length must follow the undervoltage event alone, while the cause must flip to overcurrent.

// File: rtl/gdf_pkg.sv
package gdf_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_OC   = 2'd1,
        CAUSE_UV   = 2'd2
    } cause_e;

    localparam int PHASES = 3;

    typedef struct packed {
        logic uv;
        logic pin_hi;
        logic pin_lo;
    } slow_sense_t;

    function automatic logic [PHASES-1:0] gate_mask(
        input logic [PHASES-1:0] req,
        input logic              allow
    );
        return allow ? req : '0;
    endfunction

endpackage

// File: rtl/gdf_sync.sv
module gdf_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic out_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                out_q  <= 1'b0;
            end else begin
                meta_q <= d[b];
                out_q  <= meta_q;
            end
        end
        assign q[b] = out_q;
    end
endmodule

// File: rtl/gdf_min_hold.sv
module gdf_min_hold #(
    parameter int CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic hold
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          trig_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            trig_d <= 1'b0;
        end else begin
            trig_d <= trig;
            if (trig && !trig_d)
                cnt_q <= CW'(CYC);
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CW'(1);
        end
    end

    assign hold = trig || (cnt_q != '0);
endmodule

// File: rtl/gd_fault_mgr.sv
module gd_fault_mgr
    import gdf_pkg::*;
#(
    parameter int OC_MIN_CYC = 200,
    parameter int UV_MIN_CYC = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] pwm_hi,
    input  logic [2:0] pwm_lo,
    input  logic       oc_flag,
    input  logic       uv_flag,
    input  logic       pin_high,
    input  logic       pin_low,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic       pd_en,
    output logic [1:0] fault_cause
);
    // Overcurrent keeps its first stage visible for the fast blanking path.
    logic oc_s1, oc_s2;
    always_ff @(posedge clk) begin
        if (rst) begin
            oc_s1 <= 1'b0;
            oc_s2 <= 1'b0;
        end else begin
            oc_s1 <= oc_flag;
            oc_s2 <= oc_s1;
        end
    end

    slow_sense_t raw_sense, sense;
    assign raw_sense = '{uv: uv_flag, pin_hi: pin_high, pin_lo: pin_low};

    gdf_sync #(.W($bits(slow_sense_t))) u_sync (
        .clk(clk), .rst(rst), .d(raw_sense), .q(sense)
    );

    logic uv_s2, pinh_s2, pinl_s2;
    assign uv_s2   = sense.uv;
    assign pinh_s2 = sense.pin_hi;
    assign pinl_s2 = sense.pin_lo;

    logic oc_hold, uv_hold;
    gdf_min_hold #(.CYC(OC_MIN_CYC)) u_oc_hold (
        .clk(clk), .rst(rst), .trig(oc_s2), .hold(oc_hold)
    );
    gdf_min_hold #(.CYC(UV_MIN_CYC)) u_uv_hold (
        .clk(clk), .rst(rst), .trig(uv_s2), .hold(uv_hold)
    );

    logic   pd_q, latch_q, oc_d, uv_d;
    cause_e cause_q;
    logic   [2:0] gh_q, gl_q;
    logic   fault_now, may_restart, drive_ok;

    assign fault_now   = oc_s1 || oc_s2 || uv_s2 || oc_hold || uv_hold;
    assign may_restart = !fault_now && !pd_q && pinh_s2;
    assign drive_ok    = !oc_s1 && !uv_s2 && !latch_q && pinh_s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q    <= 1'b0;
            latch_q <= 1'b0;
            oc_d    <= 1'b0;
            uv_d    <= 1'b0;
            cause_q <= CAUSE_NONE;
            gh_q    <= '0;
            gl_q    <= '0;
        end else begin
            oc_d <= oc_s2;
            uv_d <= uv_s2;

            if (oc_s2 || uv_s2)
                pd_q <= 1'b1;
            else if (!oc_hold && !uv_hold && pinl_s2)
                pd_q <= 1'b0;

            if (fault_now)
                latch_q <= 1'b1;
            else if (may_restart)
                latch_q <= 1'b0;

            if (oc_s2 && !oc_d)
                cause_q <= CAUSE_OC;
            else if (uv_s2 && !uv_d)
                cause_q <= CAUSE_UV;
            else if (latch_q && may_restart)
                cause_q <= CAUSE_NONE;

            gh_q <= gate_mask(pwm_hi, drive_ok);
            gl_q <= gate_mask(pwm_lo, drive_ok);
        end
    end

    assign gate_hi     = gh_q;
    assign gate_lo     = gl_q;
    assign pd_en       = pd_q;
    assign fault_cause = cause_q;
endmodule

// File: rtl/gdf_checker.sv
module gdf_checker (
    input logic       clk,
    input logic       rst,
    input logic       oc_flag,
    input logic       pin_high,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo,
    input logic       pd_en,
    input logic [1:0] fault_cause,
    input logic       pinl_s2,
    input logic       oc_hold,
    input logic       uv_hold
);
    logic gates_on;
    assign gates_on = (gate_hi != 3'b000) || (gate_lo != 3'b000);

    assert_oc_blank_R1: assert property (@(posedge clk) disable iff (rst)
        $past(oc_flag) |=> !gates_on);

    assert_release_needs_low_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pd_en) |-> $past(pinl_s2 && !oc_hold && !uv_hold));

    assert_gate_pd_excl_R6: assert property (@(posedge clk) disable iff (rst)
        gates_on |-> !pd_en);

    assert_pin_blank_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(pin_high, 2) |=> !gates_on);

    assert_gate_cause_R10: assert property (@(posedge clk) disable iff (rst)
        gates_on |-> (fault_cause == 2'd0));

    assert_cause_code_R10: assert property (@(posedge clk) disable iff (rst)
        fault_cause != 2'd3);
endmodule

bind gd_fault_mgr gdf_checker u_chk (
    .clk(clk), .rst(rst), .oc_flag(oc_flag), .pin_high(pin_high),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .pd_en(pd_en),
    .fault_cause(fault_cause), .pinl_s2(pinl_s2),
    .oc_hold(oc_hold), .uv_hold(uv_hold)
);

// File: tb/gd_fault_mgr_test.sv
module gd_fault_mgr_test;
    localparam int OC = 20;
    localparam int UV = 50;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] pwm_hi, pwm_lo;
    logic       oc_flag, uv_flag, pin_high, pin_low;
    logic [2:0] gate_hi, gate_lo;
    logic       pd_en;
    logic [1:0] fault_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gd_fault_mgr #(.OC_MIN_CYC(OC), .UV_MIN_CYC(UV)) uut (
        .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .oc_flag(oc_flag), .uv_flag(uv_flag), .pin_high(pin_high),
        .pin_low(pin_low), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .pd_en(pd_en), .fault_cause(fault_cause)
    );

    // {pin_high, pwm_hi, pwm_lo, exp_hi, exp_lo}
    localparam logic [12:0] VEC [8] = '{
        {1'b1, 3'b001, 3'b110, 3'b001, 3'b110},
        {1'b1, 3'b010, 3'b101, 3'b010, 3'b101},
        {1'b1, 3'b100, 3'b011, 3'b100, 3'b011},
        {1'b1, 3'b000, 3'b000, 3'b000, 3'b000},
        {1'b0, 3'b111, 3'b000, 3'b000, 3'b000},
        {1'b1, 3'b111, 3'b000, 3'b111, 3'b000},
        {1'b0, 3'b011, 3'b100, 3'b000, 3'b000},
        {1'b1, 3'b101, 3'b010, 3'b101, 3'b010}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic fault_run(input int oc_at, input int oc_len, input int uv_at,
                             input int uv_len, input int window, output int cnt);
        cnt = 0;
        for (int i = 0; i < window; i++) begin
            oc_flag = (i >= oc_at) && (i < oc_at + oc_len);
            uv_flag = (i >= uv_at) && (i < uv_at + uv_len);
            @(negedge clk);
            if (pd_en) cnt++;
        end
        oc_flag = 1'b0;
        uv_flag = 1'b0;
    endtask

    task automatic restart();
        pin_low  = 1'b1;
        repeat (4) @(negedge clk);
        pin_high = 1'b1;
        pin_low  = 1'b0;
        repeat (6) @(negedge clk);
        check(gate_hi == pwm_hi && gate_lo == pwm_lo, "R6 restart", gate_hi, pwm_hi);
        check(fault_cause == 2'd0, "R10 cleared", fault_cause, 0);
    endtask

    task automatic line_down();
        pin_high = 1'b0;
        pin_low  = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        int c;
        rst = 1'b1; pwm_hi = '0; pwm_lo = '0;
        oc_flag = 0; uv_flag = 0; pin_high = 1; pin_low = 0;
        pwm_hi = 3'b111; pwm_lo = 3'b111;
        repeat (3) @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0, "R11 gates", gate_hi, 0);
        check(pd_en == 0, "R11 pd", pd_en, 0);
        check(fault_cause == 0, "R11 cause", fault_cause, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R12 / R7 table walk
        for (int i = 0; i < 8; i++) begin
            {pin_high, pwm_hi, pwm_lo} = VEC[i][12:6];
            repeat (4) @(negedge clk);
            check(gate_hi == VEC[i][5:3], "R12 hi", gate_hi, VEC[i][5:3]);
            check(gate_lo == VEC[i][2:0], "R12 lo", gate_lo, VEC[i][2:0]);
            check(pd_en == 0, "R7 no pd", pd_en, 0);
        end

        // R1 fast blanking
        oc_flag = 1'b1;
        @(negedge clk);
        oc_flag = 1'b0;
        check(gate_hi == 3'b101, "R1 before", gate_hi, 3'b101);
        @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0, "R1 blank", {gate_hi, gate_lo}, 0);
        pin_high = 1'b0; pin_low = 1'b1;
        repeat (OC + 10) @(negedge clk);
        check(pd_en == 0, "R2 released", pd_en, 0);
        check(fault_cause == 1, "R10 oc", fault_cause, 1);
        restart();

        // R2 short overcurrent
        line_down();
        fault_run(0, 1, 0, 0, OC + 30, c);
        check(c == OC + 1, "R2 length", c, OC + 1);
        check(fault_cause == 1, "R10 oc", fault_cause, 1);
        restart();

        // R3 long overcurrent
        line_down();
        fault_run(0, OC + 15, 0, 0, OC + 60, c);
        check(c == OC + 15, "R3 length", c, OC + 15);
        restart();

        // R4 short and long undervoltage
        line_down();
        fault_run(0, 0, 0, 3, UV + 30, c);
        check(c == UV + 1, "R4 short", c, UV + 1);
        check(fault_cause == 2, "R10 uv", fault_cause, 2);
        fault_run(0, 0, 0, UV + 20, UV + 60, c);
        check(c == UV + 20, "R4 long", c, UV + 20);
        restart();

        // R8 overcurrent inside undervoltage
        line_down();
        fault_run(10, 1, 0, 80, 130, c);
        check(c == 80, "R8 length", c, 80);
        check(fault_cause == 1, "R8 cause", fault_cause, 1);
        restart();

        // R9 simultaneous start
        line_down();
        fault_run(0, 1, 0, 1, UV + 30, c);
        check(c == UV + 1, "R9 length", c, UV + 1);
        check(fault_cause == 1, "R9 R10 priority", fault_cause, 1);
        restart();

        // R5 release waits for line-low flag
        pin_high = 1'b0; pin_low = 1'b0;
        repeat (5) @(negedge clk);
        fault_run(0, 1, 0, 0, OC + 30, c);
        check(pd_en == 1, "R5 held", pd_en, 1);
        check(c == OC + 28, "R5 count", c, OC + 28);
        pin_low = 1'b1;
        repeat (4) @(negedge clk);
        check(pd_en == 0, "R5 release", pd_en, 0);
        check(gate_hi == 0 && gate_lo == 0, "R6 wait high", {gate_hi, gate_lo}, 0);
        restart();

        // R7 external pull-low
        pin_high = 1'b0;
        repeat (4) @(negedge clk);
        check(gate_hi == 0 && gate_lo == 0, "R7 blank", {gate_hi, gate_lo}, 0);
        check(pd_en == 0, "R7 pd", pd_en, 0);
        check(fault_cause == 0, "R7 cause", fault_cause, 0);
        pin_high = 1'b1;
        repeat (4) @(negedge clk);
        check(gate_hi == pwm_hi && gate_lo == pwm_lo, "R7 resume", gate_hi, pwm_hi);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule